// File: doc/BRIEF.md
# Single-Precision Underflow and Flush-to-Zero Result Stage

This stage sits at the tail of a floating-point arithmetic unit. It takes an unrounded single-precision result as sign, signed biased exponent and an extended mantissa that carries a guard bit and a sticky bit. It returns the packed 32-bit result with an underflow flag and an inexact flag. Rounding is always to nearest, ties to even.

Tininess is judged on the exact value before rounding. A result is tiny when its biased exponent is zero or negative and its mantissa is nonzero. In flush-to-zero mode a tiny result becomes a zero that keeps the sign of the exact value. Otherwise the value is shifted right into the subnormal range. The bits shifted out are folded into sticky, and the result is then rounded. Underflow is raised for a tiny result only when the delivered value is inexact. The stage has one register, so each result leaves one cycle after its input strobe.

Input format: `man_i[25]` is the integer bit, `man_i[24:2]` is the fraction, `man_i[1]` is guard and `man_i[0]` is sticky. `exp_i` is a two's-complement biased exponent (bias 127). The value is zero exactly when `man_i` is all zeros; otherwise `man_i[25]` is 1. Biased exponents above 254 after rounding are outside this stage's scope. The output is IEEE single: bit 31 sign, bits 30:23 exponent, bits 22:0 fraction.

Top module: `ufz_result_stage`

## Requirements
- R1: A result, `uf_o` and `ix_o` appear with `valid_o` high exactly one clock after `valid_i` is high, and `valid_o` is low in the cycle after a cycle with `valid_i` low.
- R2: A non-tiny result is rounded to nearest, ties to even, on guard and sticky. A carry out of the fraction increments the exponent field. `ix_o` is set exactly when guard or sticky is 1.
- R3: Tininess is decided before rounding: the input is tiny when `exp_i <= 0` and `man_i` is nonzero.
- R4: With `ftz_i` = 1, a tiny input yields `{sign_i, 31'b0}` with both `uf_o` and `ix_o` set.
- R5: With `ftz_i` = 0, a tiny input is shifted right by `1 - exp_i` positions, with all shifted-out bits ORed into sticky. It is then rounded to nearest even and delivered with exponent field 0.
- R6: With `ftz_i` = 0, a tiny result raises `uf_o` only when it is inexact. An exact subnormal raises neither flag.
- R7: A tiny, inexact value that rounds up to the smallest normal (0x00800000) still raises `uf_o` and `ix_o`.
- R8: A non-tiny result never raises `uf_o`, in either mode.
- R9: An all-zero `man_i` yields `{sign_i, 31'b0}` with neither flag, whatever `exp_i` and `ftz_i` are.
- R10: While `rst_ni` is low, `valid_o`, `result_o`, `uf_o` and `ix_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| sign_i | input | 1 | Sign of the exact result |
| exp_i | input | 10 | Signed biased exponent before rounding |
| man_i | input | 26 | Integer bit, 23 fraction bits, guard, sticky |
| ftz_i | input | 1 | Flush-to-zero mode |
| valid_o | output | 1 | Output strobe |
| result_o | output | 32 | Packed single-precision result |
| uf_o | output | 1 | Underflow flag |
| ix_o | output | 1 | Inexact flag |

## Verification
Denormalization and round-up can meet in one cycle: a tiny value can round up into the smallest normal. The bench provokes this with exponent 0 and an all-ones fraction whose shifted guard and sticky force an increment. It expects 0x00800000 with both flags set, because tininess was decided before rounding. A second vector uses the same exponent with an exact mantissa and expects a subnormal with no flags. A third applies an inexact value at exponent 1 in flush mode and expects a normal result that is not flushed.

// File: rtl/ufz_pkg.sv
package ufz_pkg;
  localparam int FRAC_W   = 23;
  localparam int EXPF_W   = 8;
  localparam int EXP_IN_W = 10;
  localparam int MAN_W    = FRAC_W + 3;
  localparam int RES_W    = 1 + EXPF_W + FRAC_W;

  typedef enum logic [1:0] {
    PATH_ZERO  = 2'd0,
    PATH_FLUSH = 2'd1,
    PATH_SUB   = 2'd2,
    PATH_NORM  = 2'd3
  } ufz_path_e;
endpackage

// File: rtl/ufz_denorm.sv
module ufz_denorm #(
  parameter int MAN_W = ufz_pkg::MAN_W,
  parameter int SH_W  = $clog2(MAN_W + 1)
) (
  input  logic [MAN_W-1:0] man_i,
  input  logic [SH_W-1:0]  sh_i,
  output logic [MAN_W-1:0] man_o
);
  logic [MAN_W-1:0] kept;
  logic [MAN_W-1:0] lost_mask;
  logic             lost;

  always_comb begin
    kept      = man_i >> sh_i;
    lost_mask = ~({MAN_W{1'b1}} << sh_i);
    lost      = |(man_i & lost_mask);
    man_o     = {kept[MAN_W-1:1], kept[0] | lost};
  end
endmodule

// File: rtl/ufz_round.sv
module ufz_round #(
  parameter int FRAC_W = ufz_pkg::FRAC_W,
  parameter int EXPF_W = ufz_pkg::EXPF_W,
  localparam int BODY_W = EXPF_W + FRAC_W
) (
  input  logic              sign_i,
  input  logic [EXPF_W-1:0] expf_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              guard_i,
  input  logic              sticky_i,
  output logic [BODY_W:0]   res_o,
  output logic              inexact_o
);
  logic inc;

  always_comb begin
    inc       = guard_i & (sticky_i | frac_i[0]);
    inexact_o = guard_i | sticky_i;
    // carry out of the fraction ripples into the exponent field
    res_o     = {sign_i, {expf_i, frac_i} + BODY_W'(inc)};
  end
endmodule

// File: rtl/ufz_result_stage.sv
module ufz_result_stage #(
  parameter int EXP_IN_W = ufz_pkg::EXP_IN_W,
  parameter int EXPF_W   = ufz_pkg::EXPF_W,
  parameter int FRAC_W   = ufz_pkg::FRAC_W,
  localparam int MAN_W   = FRAC_W + 3,
  localparam int RES_W   = 1 + EXPF_W + FRAC_W,
  localparam int SH_W    = $clog2(MAN_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                sign_i,
  input  logic [EXP_IN_W-1:0] exp_i,
  input  logic [MAN_W-1:0]    man_i,
  input  logic                ftz_i,
  output logic                valid_o,
  output logic [RES_W-1:0]    result_o,
  output logic                uf_o,
  output logic                ix_o
);
  import ufz_pkg::*;

  logic signed [EXP_IN_W-1:0] exp_s;
  logic signed [EXP_IN_W:0]   sh_full;
  logic [SH_W-1:0]            sh;
  logic                       is_zero, tiny;
  logic [MAN_W-1:0]           den_man, man_sel;
  logic [EXPF_W-1:0]          expf_sel;
  logic [RES_W-1:0]           rnd_res, res_d;
  logic                       rnd_ix, uf_d, ix_d;
  ufz_path_e                  path;

  always_comb begin
    exp_s   = $signed(exp_i);
    is_zero = (man_i == '0);
    tiny    = !is_zero && (exp_s <= 0);
    sh_full = $signed((EXP_IN_W+1)'(1)) - $signed({exp_s[EXP_IN_W-1], exp_s});
    if (!tiny)                 sh = '0;
    else if (sh_full >= MAN_W) sh = SH_W'(MAN_W);
    else                       sh = sh_full[SH_W-1:0];
  end

  ufz_denorm #(.MAN_W(MAN_W), .SH_W(SH_W)) u_denorm (
    .man_i (man_i),
    .sh_i  (sh),
    .man_o (den_man)
  );

  always_comb begin
    man_sel  = tiny ? den_man : man_i;
    // integer bit after a shift of at least one is always zero
    expf_sel = tiny ? EXPF_W'(den_man[MAN_W-1]) : exp_i[EXPF_W-1:0];
  end

  ufz_round #(.FRAC_W(FRAC_W), .EXPF_W(EXPF_W)) u_round (
    .sign_i    (sign_i),
    .expf_i    (expf_sel),
    .frac_i    (man_sel[MAN_W-2:2]),
    .guard_i   (man_sel[1]),
    .sticky_i  (man_sel[0]),
    .res_o     (rnd_res),
    .inexact_o (rnd_ix)
  );

  always_comb begin
    if (is_zero)    path = PATH_ZERO;
    else if (!tiny) path = PATH_NORM;
    else if (ftz_i) path = PATH_FLUSH;
    else            path = PATH_SUB;

    unique case (path)
      PATH_ZERO:  begin res_d = {sign_i, {(RES_W-1){1'b0}}}; uf_d = 1'b0;   ix_d = 1'b0;   end
      PATH_FLUSH: begin res_d = {sign_i, {(RES_W-1){1'b0}}}; uf_d = 1'b1;   ix_d = 1'b1;   end
      PATH_SUB:   begin res_d = rnd_res;                     uf_d = rnd_ix; ix_d = rnd_ix; end
      default:    begin res_d = rnd_res;                     uf_d = 1'b0;   ix_d = rnd_ix; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      uf_o     <= 1'b0;
      ix_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        uf_o     <= uf_d;
        ix_o     <= ix_d;
      end
    end
  end

  // R4
  flush_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_i && tiny && ftz_i)
      |-> (result_o[RES_W-2:0] == '0) && uf_o && ix_o);

  // R8
  no_uf_when_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_i && !tiny) |-> !uf_o);

  // R6
  uf_implies_ix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && uf_o |-> ix_o);

  // R9
  zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_i && (man_i == '0))
      |-> !uf_o && !ix_o && (result_o[RES_W-2:0] == '0));

  // R5
  denorm_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_i && tiny && !ftz_i)
      |-> result_o[RES_W-2:FRAC_W] <= EXPF_W'(1));

  // R1
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

// File: tb/ufz_result_stage_tb.sv
module ufz_result_stage_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        sign_i = 1'b0;
  logic [9:0]  exp_i = '0;
  logic [25:0] man_i = '0;
  logic        ftz_i = 1'b0;
  logic        valid_o, uf_o, ix_o;
  logic [31:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  ufz_result_stage dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sign_i(sign_i),
    .exp_i(exp_i), .man_i(man_i), .ftz_i(ftz_i), .valid_o(valid_o),
    .result_o(result_o), .uf_o(uf_o), .ix_o(ix_o)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(string req, logic s, logic [9:0] e, logic [25:0] m, logic f,
                       logic [31:0] e_res, logic e_uf, logic e_ix);
    @(negedge clk_i);
    valid_i = 1'b1; sign_i = s; exp_i = e; man_i = m; ftz_i = f;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " result"}, result_o, e_res);
    check({req, " uf"}, {31'b0, uf_o}, {31'b0, e_uf});
    check({req, " ix"}, {31'b0, ix_o}, {31'b0, e_ix});
    check("R1 valid", {31'b0, valid_o}, 32'd1);
  endtask

  task automatic t_reset;
    check("R10 valid", {31'b0, valid_o}, 32'd0);
    check("R10 result", result_o, 32'd0);
    check("R10 flags", {30'b0, uf_o, ix_o}, 32'd0);
  endtask

  task automatic t_normal;
    apply("R2 exact", 1'b0, 10'd127, {1'b1, 23'h0, 1'b0, 1'b0}, 1'b0, 32'h3F800000, 1'b0, 1'b0);
    apply("R2 tie even", 1'b0, 10'd127, {1'b1, 23'h0, 1'b1, 1'b0}, 1'b0, 32'h3F800000, 1'b0, 1'b1);
    apply("R2 tie odd", 1'b0, 10'd127, {1'b1, 23'h1, 1'b1, 1'b0}, 1'b0, 32'h3F800002, 1'b0, 1'b1);
    apply("R2 carry", 1'b1, 10'd127, {1'b1, 23'h7FFFFF, 1'b1, 1'b1}, 1'b0, 32'hC0000000, 1'b0, 1'b1);
  endtask

  task automatic t_flush;
    apply("R4 flush", 1'b1, 10'd0, {1'b1, 23'h0, 1'b0, 1'b0}, 1'b1, 32'h80000000, 1'b1, 1'b1);
    apply("R3 R4 flush deep", 1'b0, 10'h3FB, {1'b1, 23'h12345, 1'b0, 1'b1}, 1'b1, 32'h0, 1'b1, 1'b1);
  endtask

  task automatic t_subnormal;
    apply("R6 exact sub", 1'b0, 10'd0, {1'b1, 23'h0, 1'b0, 1'b0}, 1'b0, 32'h00400000, 1'b0, 1'b0);
    apply("R5 R6 inexact sub", 1'b0, 10'h3FF, {1'b1, 23'h1, 1'b0, 1'b0}, 1'b0, 32'h00200000, 1'b1, 1'b1);
    apply("R5 shifted sticky", 1'b1, 10'd0, {1'b1, 23'h0, 1'b1, 1'b0}, 1'b0, 32'h80400000, 1'b1, 1'b1);
    apply("R5 deep shift", 1'b0, 10'h3D8, {1'b1, 23'h0, 1'b0, 1'b0}, 1'b0, 32'h0, 1'b1, 1'b1);
  endtask

  task automatic t_min_normal;
    apply("R7 round to min normal", 1'b0, 10'd0, {1'b1, 23'h7FFFFF, 1'b1, 1'b0}, 1'b0,
          32'h00800000, 1'b1, 1'b1);
    apply("R8 exp one ftz", 1'b0, 10'd1, {1'b1, 23'h0, 1'b0, 1'b1}, 1'b1, 32'h00800000, 1'b0, 1'b1);
  endtask

  task automatic t_zero;
    apply("R9 zero ftz", 1'b1, 10'h3FB, 26'h0, 1'b1, 32'h80000000, 1'b0, 1'b0);
    apply("R9 zero noftz", 1'b0, 10'd0, 26'h0, 1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_latency;
    @(negedge clk_i);
    check("R1 idle", {31'b0, valid_o}, 32'd0);
    @(negedge clk_i);
    check("R1 idle hold", {31'b0, valid_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_normal();
    t_latency();
    t_flush();
    t_subnormal();
    t_min_normal();
    t_zero();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule